// File: doc/BRIEF.md
# Byte-Serial Operand Port with Parity Check

This block is the byte-wide front end of a modular-inverse engine. A host writes a 34-byte operand frame one byte per write strobe; the block assembles it in a 272-bit shift register and checks its even-parity bit. It then hands the 256-bit operand to an arithmetic core through a one-cycle start pulse. When the core reports completion, the block captures an output frame and the host drains it one byte per read strobe.

Both strobes act only on their rising edge, after a two-flop synchronizer. While the core is running, a second operand frame can be written and held. A single write strobe after the first result starts the held operand without resending it.

A two-bit mode input chooses the output frame when the result is captured: the inverse result, or the core's performance counters with a status byte. In the read state the mode can also select a live random-byte pass-through, which has its own consume strobe.

Top module: `serial_operand_port`

## Requirements
- R1: After reset, ready is 1, valid is 0, parity_error is 0, dout is 0x00, core_start is 0 and no operand is held.
- R2: wr and rd act once per rising edge. A strobe held high for many cycles shifts exactly one byte in or out.
- R3: Bytes enter MSB first. Frame bits 271..16 (the first 32 bytes) form the operand. On the 34th byte in the load state, core_operand takes that value and core_start pulses for exactly one cycle.
- R4: The parity bit is frame bit 15, the MSB of byte 33. If the XOR of the 256 operand bits and that bit is 1, parity_error becomes 1, otherwise 0. It is updated only in the cycle a computation starts and reflects the operand being computed.
- R5: core_done in the busy state raises valid, drops ready, and presents the first output byte on dout in the next cycle. ready and valid are never both 1.
- R6: With mode 00 or 11 at capture, the output frame is the 32 result bytes MSB first, then the byte {even parity of the result, parity_error, 6'b0}, then 0x00.
- R7: With mode 01 at capture, the output frame is cnt_cycles, cnt_double, cnt_triple and cnt_iter (16 bits each, MSB first), then the status byte {parity_error, rnd_ready, 6'b0}, then zero bytes.
- R8: In the read state with mode 10, dout shows rnd_byte. An rd edge there pulses rnd_take for one cycle only if rnd_ready is 1, and it never shifts the output frame.
- R9: In the busy state, a second 34-byte frame is accepted and held, and ready drops once it is complete. Further writes are ignored until that frame is used. In the read state, one wr edge starts the held operand and applies its own parity result.
- R10: A wr edge in the read state with no held operand returns the block to the load state without capturing the byte.
- R11: After all 34 output bytes have been read, further rd edges shift out 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 8 | Write data byte |
| wr | input | 1 | Write strobe (rising edge) |
| rd | input | 1 | Read strobe (rising edge) |
| mode | input | 2 | Output frame / pass-through select |
| dout | output | 8 | Read data byte |
| ready | output | 1 | Block accepts operand bytes |
| valid | output | 1 | Output frame available |
| parity_error | output | 1 | Parity check failed for the current operand |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_operand | output | 256 | Operand for the core |
| core_done | input | 1 | Core finished |
| core_result | input | 256 | Core result |
| cnt_cycles | input | 16 | Core cycle counter |
| cnt_double | input | 16 | Core double-step counter |
| cnt_triple | input | 16 | Core triple-step counter |
| cnt_iter | input | 16 | Core iteration counter |
| rnd_byte | input | 8 | Random byte from the generator |
| rnd_ready | input | 1 | Random byte available |
| rnd_take | output | 1 | One-cycle consume pulse to the generator |

## Verification
The hardest situation to reach is a held second operand. The stimulus writes a full frame during the busy window, before the bench core is told to finish. To show that writes are ignored once the held frame is complete, it adds a surplus byte. The held frame carries a deliberately wrong parity bit, while the first frame carries a correct one. When the read-state write strobe starts the held operand, the bench checks two things: parity_error flips from the first operand's value to the held one's, and the operand matches the held frame byte for byte.

// File: rtl/serial_operand_port.sv
module serial_operand_port #(
  parameter int DATA_W      = 256,
  parameter int FRAME_BYTES = 34,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        din,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        mode,
  output logic [7:0]        dout,
  output logic              ready,
  output logic              valid,
  output logic              parity_error,
  output logic              core_start,
  output logic [DATA_W-1:0] core_operand,
  input  logic              core_done,
  input  logic [DATA_W-1:0] core_result,
  input  logic [CNT_W-1:0]  cnt_cycles,
  input  logic [CNT_W-1:0]  cnt_double,
  input  logic [CNT_W-1:0]  cnt_triple,
  input  logic [CNT_W-1:0]  cnt_iter,
  input  logic [7:0]        rnd_byte,
  input  logic              rnd_ready,
  output logic              rnd_take
);
  localparam int FRAME_W = FRAME_BYTES * 8;
  localparam int PAR_POS = FRAME_W - DATA_W - 1;
  localparam int BCW     = $clog2(FRAME_BYTES);
  localparam int CPAD    = FRAME_W - 4 * CNT_W - 8;

  typedef enum logic [1:0] {ST_FILL, ST_RUN, ST_DRAIN} st_t;
  st_t st;

  logic [2:0]         wr_q, rd_q;
  logic [FRAME_W-1:0] in_sr, out_sr;
  logic [BCW-1:0]     cnt;
  logic               queued, q_perr;

  wire wr_e = wr_q[1] & ~wr_q[2];
  wire rd_e = rd_q[1] & ~rd_q[2];

  wire [FRAME_W-1:0] in_next  = {in_sr[FRAME_W-9:0], din};
  wire               in_bad   = ^{in_next[FRAME_W-1 -: DATA_W], in_next[PAR_POS]};
  wire               last     = (cnt == BCW'(FRAME_BYTES - 1));
  wire               take     = wr_e & ((st == ST_FILL) | (st == ST_RUN & ~queued));
  wire               rnd_mode = (mode == 2'b10);

  wire [FRAME_W-1:0] res_frame = {core_result, ^core_result, parity_error,
                                  {(FRAME_W-DATA_W-2){1'b0}}};
  wire [FRAME_W-1:0] cnt_frame = {cnt_cycles, cnt_double, cnt_triple, cnt_iter,
                                  parity_error, rnd_ready, 6'b0, {CPAD{1'b0}}};

  assign ready = (st == ST_FILL) | (st == ST_RUN & ~queued);
  assign valid = (st == ST_DRAIN);
  assign dout  = (valid & rnd_mode) ? rnd_byte : out_sr[FRAME_W-1 -: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_FILL;
      wr_q         <= '0;
      rd_q         <= '0;
      in_sr        <= '0;
      out_sr       <= '0;
      cnt          <= '0;
      queued       <= 1'b0;
      q_perr       <= 1'b0;
      parity_error <= 1'b0;
      core_start   <= 1'b0;
      core_operand <= '0;
      rnd_take     <= 1'b0;
    end else begin
      wr_q       <= {wr_q[1:0], wr};
      rd_q       <= {rd_q[1:0], rd};
      core_start <= 1'b0;
      rnd_take   <= 1'b0;
      if (take) begin
        in_sr <= in_next;
        cnt   <= last ? '0 : cnt + 1'b1;
      end
      case (st)
        ST_FILL: if (take && last) begin
          core_operand <= in_next[FRAME_W-1 -: DATA_W];
          parity_error <= in_bad;
          core_start   <= 1'b1;
          st           <= ST_RUN;
        end
        ST_RUN: begin
          if (take && last) begin
            queued <= 1'b1;
            q_perr <= in_bad;
          end
          if (core_done) begin
            out_sr <= (mode == 2'b01) ? cnt_frame : res_frame;
            st     <= ST_DRAIN;
          end
        end
        default: begin
          if (wr_e) begin
            if (queued) begin
              core_operand <= in_sr[FRAME_W-1 -: DATA_W];
              parity_error <= q_perr;
              queued       <= 1'b0;
              core_start   <= 1'b1;
              st           <= ST_RUN;
            end else begin
              st <= ST_FILL;
            end
          end else if (rd_e) begin
            if (rnd_mode) rnd_take <= rnd_ready;
            else          out_sr   <= {out_sr[FRAME_W-9:0], 8'h00};
          end
        end
      endcase
    end
  end

  // R5
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && valid));
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);
  // R4
  perr_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(parity_error) |-> core_start);
  // R8
  rnd_take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_take |-> $past(rnd_ready));
  // R8
  rnd_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && rnd_mode) |=> $stable(out_sr));
  // R9
  no_queue_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FILL) |-> !queued);
endmodule

// File: tb/test_serial_operand_port.sv
`timescale 1ns/1ps
module test_serial_operand_port;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic [7:0]   din = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [7:0]   dout;
  logic         ready, valid, parity_error, core_start, rnd_take;
  logic [255:0] core_operand;
  logic         core_done = 1'b0;
  logic [255:0] core_result = '0;
  logic [15:0]  cnt_cycles = '0, cnt_double = '0, cnt_triple = '0, cnt_iter = '0;
  logic [7:0]   rnd_byte = '0;
  logic         rnd_ready = 1'b0;

  int n_chk = 0, n_bad = 0, starts = 0, takes = 0;
  logic [255:0] last_op = '0;
  logic [255:0] op_a, op_b, op_c, res_a;

  always #2.5 clk = ~clk;

  serial_operand_port i_serial_operand_port (
    .clk, .rst_n, .din, .wr, .rd, .mode, .dout, .ready, .valid, .parity_error,
    .core_start, .core_operand, .core_done, .core_result, .cnt_cycles,
    .cnt_double, .cnt_triple, .cnt_iter, .rnd_byte, .rnd_ready, .rnd_take);

  always @(posedge clk) if (rst_n) begin
    if (core_start) begin starts++; last_op = core_operand; end
    if (rnd_take) takes++;
  end

  task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [271:0] in_frame(logic [255:0] d, bit bad);
    return {d, (^d) ^ bad, 15'b0};
  endfunction
  function automatic logic [271:0] res_frame(logic [255:0] r, bit pe);
    return {r, ^r, pe, 14'b0};
  endfunction

  task automatic put_byte(logic [7:0] b, int hold = 4);
    @(negedge clk); din = b; wr = 1'b1;
    repeat (hold) @(negedge clk);
    wr = 1'b0;
    repeat (4) @(negedge clk);
  endtask
  task automatic pulse_rd(int hold = 4);
    @(negedge clk); rd = 1'b1;
    repeat (hold) @(negedge clk);
    rd = 1'b0;
    repeat (4) @(negedge clk);
  endtask
  task automatic send(logic [271:0] f, int nbytes = 34, int hold0 = 4);
    for (int i = 0; i < nbytes; i++) put_byte(f[271-8*i -: 8], (i == 0) ? hold0 : 4);
  endtask
  task automatic finish_core(logic [255:0] r);
    @(negedge clk); core_result = r; core_done = 1'b1;
    @(negedge clk); core_done = 1'b0;
    @(negedge clk);
  endtask
  task automatic read_frame(string tag, logic [271:0] f, int long_at = -1);
    chk({tag, " byte0"}, dout, f[271:264]);
    for (int i = 1; i < 34; i++) begin
      pulse_rd((i == long_at) ? 12 : 4);
      chk($sformatf("%s byte%0d", tag, i), dout, f[271-8*i -: 8]);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk("R1 ready", ready, 1); chk("R1 valid", valid, 0);
    chk("R1 parity_error", parity_error, 0); chk("R1 dout", dout, 0);
    chk("R1 core_start", core_start, 0);
  endtask

  task automatic t_load_first;
    send(in_frame(op_a, 0), 34, 14);
    chk("R3 start count", starts, 1);
    chk("R2 R3 operand A", last_op, op_a);
    chk("R4 good parity", parity_error, 0);
    chk("R9 ready while busy", ready, 1);
  endtask

  task automatic t_queue_second;
    send(in_frame(op_b, 1));
    chk("R9 ready low when held", ready, 0);
    chk("R4 no update while held", parity_error, 0);
    put_byte(8'hEE);
    chk("R9 no extra start", starts, 1);
  endtask

  task automatic t_read_result;
    mode = 2'b00;
    finish_core(res_a);
    chk("R5 valid", valid, 1); chk("R5 ready", ready, 0);
    read_frame("R6 R2 result", res_frame(res_a, 0), 5);
  endtask

  task automatic t_start_queued;
    put_byte(8'h11);
    chk("R9 start count", starts, 2);
    chk("R9 held operand", last_op, op_b);
    chk("R4 R9 bad parity", parity_error, 1);
    chk("R9 valid low", valid, 0);
    chk("R9 ready again", ready, 1);
  endtask

  task automatic t_counters_and_random;
    logic [271:0] f;
    mode = 2'b01; rnd_ready = 1'b1;
    cnt_cycles = 16'h014F; cnt_double = 16'h0033; cnt_triple = 16'h0012; cnt_iter = 16'h02E6;
    finish_core(~res_a);
    f = {16'h014F, 16'h0033, 16'h0012, 16'h02E6, 8'hC0, 200'b0};
    @(negedge clk); mode = 2'b10; rnd_byte = 8'h5A; @(negedge clk);
    chk("R8 pass-through", dout, 8'h5A);
    pulse_rd();
    chk("R8 take with ready", takes, 1);
    rnd_ready = 1'b0;
    pulse_rd();
    chk("R8 no take without ready", takes, 1);
    mode = 2'b00; @(negedge clk);
    read_frame("R7 counters", f);
  endtask

  task automatic t_return_and_mode11;
    put_byte(8'h77);
    chk("R10 ready", ready, 1); chk("R10 valid", valid, 0);
    chk("R10 no start", starts, 2);
    send(in_frame(op_c, 0), 33);
    chk("R10 byte not captured", starts, 2);
    put_byte(in_frame(op_c, 0)[7:0]);
    chk("R10 start after 34", starts, 3);
    chk("R3 operand C", last_op, op_c);
    chk("R4 good parity C", parity_error, 0);
    mode = 2'b11;
    finish_core(op_c ^ res_a);
    read_frame("R6 mode11", res_frame(op_c ^ res_a, 0));
    pulse_rd();
    chk("R11 zero fill", dout, 8'h00);
  endtask

  initial begin
    op_a  = {8{32'hA5C3_1E7F}};
    op_b  = {8{32'h0F1E_2D3C}} ^ 256'h1;
    op_c  = {4{64'h1357_9BDF_0246_8ACE}};
    res_a = {8{32'h600D_F00D}} ^ 256'h3;
    t_reset;
    t_load_first;
    t_queue_second;
    t_read_result;
    t_start_queued;
    t_counters_and_random;
    t_return_and_mode11;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule